// File: doc/BRIEF.md
# Interrupt Status Poll Responder

This block answers the periodic interrupt poll that a host issues. It looks at a row of interrupt status bytes, where byte zero is a summary byte that is nonzero whenever any source is pending. When a poll strobe arrives and the summary byte is nonzero, the block takes a snapshot of every status byte in that cycle. It then streams the snapshot as one packet, one byte per cycle, with a valid marker and a last marker. When the summary byte is zero, it answers with a single-cycle NAK pulse and sends no data.

After the last byte of a packet, the block raises a one-cycle clear strobe. A clear mask comes with it, carrying the bits that were reported, so that the status sources can drop exactly those bits. The block ignores polls from the cycle that accepts a packet up to and including the cycle of the clear strobe. The status sources and the bus signalling layer sit outside this block.

Top module: `irq_poll_responder`

## Requirements
- R1: While reset is held and in the first cycle after it, tx_valid_o, tx_last_o, nak_o and clr_o are low, and clr_mask_o is zero.
- R2: A poll sampled at a clock edge while the block is idle, with a nonzero summary byte stat_i[7:0], starts a packet. In the four cycles that follow that edge, tx_valid_o is high and tx_data_o carries stat_i[8i+7:8i] for i = 0, 1, 2, 3 in turn, so the summary byte comes first.
- R3: tx_last_o is high in the fourth byte cycle of a packet and low in the other byte cycles.
- R4: A poll sampled while idle with stat_i[7:0] equal to zero makes nak_o high for exactly the following cycle and sends no data, whatever the other status bytes hold.
- R5: The packet carries the status values captured at the accepting edge. Changes on stat_i after that edge do not change the bytes sent.
- R6: In the cycle after the last byte, clr_o is high for one cycle, tx_valid_o is low, and clr_mask_o equals the captured status word.
- R7: Polls that arrive while a packet is being sent, or during the clear strobe cycle, produce no NAK and no new packet.
- R8: When the poll is held high with a nonzero summary, the next packet is accepted at the first edge after the clear cycle, so packets start six cycles apart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| poll_i | input | 1 | Poll request strobe from the host side |
| stat_i | input | 32 | Status bytes; byte i is in bits 8i+7:8i, and byte 0 is the summary |
| tx_data_o | output | 8 | Packet byte |
| tx_valid_o | output | 1 | tx_data_o holds a packet byte |
| tx_last_o | output | 1 | Marks the final byte of a packet |
| nak_o | output | 1 | One-cycle NAK answer to a poll with a zero summary |
| clr_o | output | 1 | One-cycle clear strobe after a packet |
| clr_mask_o | output | 32 | Reported bits to clear, valid while clr_o is high |

## Verification
The hardest conditions to reach are a poll landing on the exact clear cycle, and status inputs changing partway through a packet. Both lie in a narrow window between two packets. In every vector the bench keeps the poll asserted through the whole packet and the clear cycle, and it drives the bitwise inverse of the status word right after the accepting edge. Any re-acceptance or late sampling then shows up as a wrong byte, a stray NAK or an early packet. A separate test holds the poll high continuously and checks that the second packet starts exactly six cycles after the first.

// File: rtl/irq_poll_pkg.sv
package irq_poll_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SEND  = 2'd1,
    ST_CLEAR = 2'd2
  } poll_state_t;
endpackage

// File: rtl/irq_poll_snapshot.sv
module irq_poll_snapshot #(
  parameter int NUM_REGS = 4,
  parameter int BYTE_W   = 8,
  localparam int WORD_W  = NUM_REGS * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_i,
  input  logic [WORD_W-1:0] stat_i,
  output logic [WORD_W-1:0] snap_o,
  output logic              sum_nz_o
);
  assign sum_nz_o = |stat_i[BYTE_W-1:0];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        snap_o[g*BYTE_W +: BYTE_W] <= '0;
      end else if (cap_i) begin
        snap_o[g*BYTE_W +: BYTE_W] <= stat_i[g*BYTE_W +: BYTE_W];
      end
    end
  end

  // R5: the snapshot changes only at a capture edge
  p_snap_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !$past(cap_i) && !$past(rst) |-> $stable(snap_o));
endmodule

// File: rtl/irq_poll_bytesel.sv
module irq_poll_bytesel #(
  parameter int NUM_REGS = 4,
  parameter int BYTE_W   = 8,
  localparam int WORD_W  = NUM_REGS * BYTE_W,
  localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic [WORD_W-1:0] word_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [BYTE_W-1:0] byte_o
);
  logic [BYTE_W-1:0] lanes [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_lane
    assign lanes[g] = word_i[g*BYTE_W +: BYTE_W];
  end

  always_comb begin
    byte_o = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (idx_i == IDX_W'(i)) byte_o = lanes[i];
    end
  end
endmodule

// File: rtl/irq_poll_ctrl.sv
module irq_poll_ctrl
  import irq_poll_pkg::*;
#(
  parameter int NUM_REGS = 4,
  parameter int BYTE_W   = 8,
  localparam int WORD_W  = NUM_REGS * BYTE_W,
  localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              poll_i,
  input  logic              sum_nz_i,
  input  logic [BYTE_W-1:0] first_byte_i,
  input  logic [BYTE_W-1:0] sel_byte_i,
  input  logic [WORD_W-1:0] snap_i,
  output logic              cap_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [BYTE_W-1:0] tx_data_o,
  output logic              tx_valid_o,
  output logic              tx_last_o,
  output logic              nak_o,
  output logic              clr_o,
  output logic [WORD_W-1:0] clr_mask_o
);
  poll_state_t state_q;
  logic        idle_poll;

  assign idle_poll = (state_q == ST_IDLE) && poll_i;
  assign cap_o     = idle_poll && sum_nz_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      idx_o      <= '0;
      tx_data_o  <= '0;
      tx_valid_o <= 1'b0;
      tx_last_o  <= 1'b0;
      nak_o      <= 1'b0;
      clr_o      <= 1'b0;
      clr_mask_o <= '0;
    end else begin
      nak_o <= idle_poll && !sum_nz_i;
      clr_o <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          clr_mask_o <= '0;
          if (cap_o) begin
            state_q    <= ST_SEND;
            tx_data_o  <= first_byte_i;
            tx_valid_o <= 1'b1;
            tx_last_o  <= (NUM_REGS == 1);
            idx_o      <= IDX_W'(1);
          end
        end
        ST_SEND: begin
          if (tx_last_o) begin
            state_q    <= ST_CLEAR;
            tx_valid_o <= 1'b0;
            tx_last_o  <= 1'b0;
            clr_o      <= 1'b1;
            clr_mask_o <= snap_i;
          end else begin
            tx_data_o <= sel_byte_i;
            tx_last_o <= (idx_o == IDX_W'(NUM_REGS - 1));
            idx_o     <= idx_o + IDX_W'(1);
          end
        end
        default: begin
          state_q <= ST_IDLE;
        end
      endcase
    end
  end

  // R3: last marker only on a valid byte
  p_last_valid_r3: assert property (@(posedge clk) disable iff (rst)
    tx_last_o |-> tx_valid_o);
  // R4: NAK and data never together
  p_nak_excl_r4: assert property (@(posedge clk) disable iff (rst)
    !(nak_o && tx_valid_o));
  // R2: a packet opens with a nonzero summary byte
  p_first_nz_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_valid_o) |-> (tx_data_o != '0));
  // R6: clear strobe follows the last byte and lasts one cycle
  p_clr_after_last_r6: assert property (@(posedge clk) disable iff (rst)
    tx_valid_o && tx_last_o |=> clr_o && !tx_valid_o);
  p_clr_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    clr_o |=> !clr_o);
  // R7: a packet in flight is not cut or restarted by polls
  p_no_restart_r7: assert property (@(posedge clk) disable iff (rst)
    tx_valid_o && !tx_last_o |=> tx_valid_o);
  p_no_nak_busy_r7: assert property (@(posedge clk) disable iff (rst)
    tx_valid_o || clr_o |=> !nak_o);
endmodule

// File: rtl/irq_poll_responder.sv
module irq_poll_responder #(
  parameter int NUM_REGS = 4,
  parameter int BYTE_W   = 8,
  localparam int WORD_W  = NUM_REGS * BYTE_W,
  localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              poll_i,
  input  logic [WORD_W-1:0] stat_i,
  output logic [BYTE_W-1:0] tx_data_o,
  output logic              tx_valid_o,
  output logic              tx_last_o,
  output logic              nak_o,
  output logic              clr_o,
  output logic [WORD_W-1:0] clr_mask_o
);
  logic              cap;
  logic              sum_nz;
  logic [WORD_W-1:0] snap;
  logic [IDX_W-1:0]  idx;
  logic [BYTE_W-1:0] sel_byte;

  irq_poll_snapshot #(.NUM_REGS(NUM_REGS), .BYTE_W(BYTE_W)) snap_i (
    .clk      (clk),
    .rst      (rst),
    .cap_i    (cap),
    .stat_i   (stat_i),
    .snap_o   (snap),
    .sum_nz_o (sum_nz)
  );

  irq_poll_bytesel #(.NUM_REGS(NUM_REGS), .BYTE_W(BYTE_W)) sel_i (
    .word_i (snap),
    .idx_i  (idx),
    .byte_o (sel_byte)
  );

  irq_poll_ctrl #(.NUM_REGS(NUM_REGS), .BYTE_W(BYTE_W)) ctrl_i (
    .clk          (clk),
    .rst          (rst),
    .poll_i       (poll_i),
    .sum_nz_i     (sum_nz),
    .first_byte_i (stat_i[BYTE_W-1:0]),
    .sel_byte_i   (sel_byte),
    .snap_i       (snap),
    .cap_o        (cap),
    .idx_o        (idx),
    .tx_data_o    (tx_data_o),
    .tx_valid_o   (tx_valid_o),
    .tx_last_o    (tx_last_o),
    .nak_o        (nak_o),
    .clr_o        (clr_o),
    .clr_mask_o   (clr_mask_o)
  );

  // R6: the clear mask always includes a nonzero summary
  p_mask_sum_r6: assert property (@(posedge clk) disable iff (rst)
    clr_o |-> (clr_mask_o[BYTE_W-1:0] != '0));
endmodule

// File: tb/irq_poll_responder_tb_top.sv
module irq_poll_responder_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        poll_i = 1'b0;
  logic [31:0] stat_i = '0;
  logic [7:0]  tx_data_o;
  logic        tx_valid_o, tx_last_o, nak_o, clr_o;
  logic [31:0] clr_mask_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  irq_poll_responder dut_i (
    .clk(clk), .rst(rst), .poll_i(poll_i), .stat_i(stat_i),
    .tx_data_o(tx_data_o), .tx_valid_o(tx_valid_o), .tx_last_o(tx_last_o),
    .nak_o(nak_o), .clr_o(clr_o), .clr_mask_o(clr_mask_o)
  );

  // bit 32: a NAK is expected; bits 31:0: status word
  localparam logic [32:0] VECS [7] = '{
    {1'b0, 32'h0000_00A5},
    {1'b0, 32'h1234_5601},
    {1'b1, 32'hFFFF_FF00},
    {1'b1, 32'h0000_0000},
    {1'b0, 32'h80FF_7F40},
    {1'b0, 32'hFFFF_FFFF},
    {1'b1, 32'h0100_0000}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 valid", 64'(tx_valid_o), 64'd0);
    chk("R1 nak", 64'(nak_o), 64'd0);
    rst = 1'b0;
    tick();
    chk("R1 outputs idle", {clr_mask_o, 28'd0, tx_valid_o, tx_last_o, nak_o, clr_o}, 64'd0);

    for (int v = 0; v < 7; v++) begin
      logic [31:0] w;
      w = VECS[v][31:0];
      poll_i = 1'b1;
      stat_i = w;
      tick();
      if (VECS[v][32]) begin
        chk("R4 nak", 64'(nak_o), 64'd1);
        chk("R4 no data", 64'(tx_valid_o), 64'd0);
        poll_i = 1'b0;
        tick();
        chk("R4 nak one cycle", 64'(nak_o), 64'd0);
      end else begin
        chk("R2 byte0", {tx_valid_o, tx_data_o}, {1'b1, w[7:0]});
        chk("R3 not last", 64'(tx_last_o), 64'd0);
        stat_i = ~w;  // R5 and R7: changed status, poll kept high
        for (int b = 1; b < 4; b++) begin
          tick();
          chk("R5 byte", {tx_valid_o, tx_data_o}, {1'b1, w[b*8 +: 8]});
          chk("R7 no nak", 64'(nak_o), 64'd0);
          chk("R3 last", 64'(tx_last_o), 64'(b == 3));
        end
        tick();
        chk("R6 clear", {clr_o, tx_valid_o, clr_mask_o}, {1'b1, 1'b0, w});
        tick();
        chk("R7 poll in clear ignored", {tx_valid_o, nak_o, clr_o}, 3'b000);
        poll_i = 1'b0;
      end
      tick();
    end

    // R8: held poll, packets six cycles apart
    stat_i = 32'hA1B2_C3D4;
    poll_i = 1'b1;
    tick();
    chk("R8 first packet", {tx_valid_o, tx_data_o}, {1'b1, 8'hD4});
    for (int c = 1; c < 6; c++) begin
      tick();
      if (c == 5) chk("R8 gap before restart", 64'(tx_valid_o), 64'd0);
    end
    tick();
    chk("R8 second packet", {tx_valid_o, tx_data_o}, {1'b1, 8'hD4});
    poll_i = 1'b0;
    repeat (6) tick();

    // R4: held poll, zero summary, NAK each cycle
    stat_i = 32'h5500_0000;
    poll_i = 1'b1;
    tick();
    chk("R4 held nak a", {nak_o, tx_valid_o}, 2'b10);
    tick();
    chk("R4 held nak b", {nak_o, tx_valid_o}, 2'b10);
    poll_i = 1'b0;
    tick();
    chk("R4 nak ends", 64'(nak_o), 64'd0);

    // R1: reset mid-packet
    stat_i = 32'h0000_0011;
    poll_i = 1'b1;
    tick();
    rst = 1'b1;
    poll_i = 1'b0;
    tick();
    chk("R1 reset mid packet", {tx_valid_o, clr_o, nak_o}, 3'b000);
    rst = 1'b0;
    tick();
    finish_run();
  end
endmodule